// File: doc/BRIEF.md
# Fuse Controller Register Front End with Passcode Lock and Interrupts

This block is the 32-bit register front end of a one-time-programmable fuse controller. A simple word bus (address, write enable, write data, combinational read data) reaches a small register set. A lock register guards that set. After reset, every write except a write to the lock register is discarded. A 32-bit passcode write opens the set, and any other value written to the lock register closes it again.

The rest of the register set is the interrupt logic. Single-cycle event pulses arrive from the fuse program and read engines and set sticky status bits. There are fifteen general sources and one bus-error source. Software clears status bits by writing ones to them. The mask cannot be written directly: software clears mask bits through an enable address and sets them through a disable address. A registered, level-sensitive interrupt output is high while any status bit is set and not masked.

Top module: `fuse_reg_front`

## Requirements
- R1: The lock register (address 0x00) reads 1 after reset. A write of exactly 0x0000DF0D stores 0, and any other 32-bit value stores 1. It reads back as the stored value in bit 0.
- R2: While the lock register holds 1, writes to every other address are discarded. Status, mask and read-back are unchanged.
- R3: Writes to the lock register are always accepted, so writing a non-passcode value while unlocked locks the block again.
- R4: The status register (address 0x10) holds bits 0 to 14 and bit 31, and bits 15 to 30 read as zero. Writing a 1 to an implemented bit clears it, and writing 0 leaves it unchanged.
- R5: Event input bit i (i = 0..14) sets status bit i, and the bus-error event sets status bit 31. The setting happens at the clock edge where the pulse is high. An event and a write-one-to-clear on the same bit in the same cycle leave the bit set, and only such writes ever clear a bit.
- R6: The mask register (address 0x14) resets to 0x80007FFF, so all sources are masked. A direct write to it has no effect.
- R7: A write to the enable address (0x18) clears the written mask bits, and a write to the disable address (0x1C) sets them. Reserved bits stay zero, and both addresses read as zero.
- R8: The interrupt output is registered. One clock after any status or mask update, it equals the OR of status AND NOT mask.
- R9: Only whole 32-bit words are accessed. Reads of unmapped addresses return zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the word access |
| busWrEn | input | 1 | Write strobe, one write per high cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| evtPulse | input | 15 | Event pulses for status bits 0..14 (0 program done, 1 program error, 2 read done, 3 read error) |
| busErrEvt | input | 1 | Bus-error event, sets status bit 31 |
| irqOut | output | 1 | Level interrupt, registered |

## Verification
A write or an event pulse updates the register at the same rising edge that samples it. The bench therefore drives on the falling edge and reads back at the next falling edge, with no wait. The interrupt follows one edge later. After every status or mask update, the bench first checks at the immediate falling edge that the interrupt still holds its old level. It then advances one clock and checks the new level. Read data is combinational, so reads are sampled 1 ns after a falling edge, well clear of any rising edge.

// File: rtl/fuse_reg_pkg.sv
package fuse_reg_pkg;

  localparam int DataW = 32;

  // Decoded write strobes from control to datapath
  typedef struct packed {
    logic lockWr;
    logic statW1c;
    logic enWr;
    logic disWr;
  } regStrobe_t;

endpackage

// File: rtl/fuse_reg_ctrl.sv
module fuse_reg_ctrl
  import fuse_reg_pkg::*;
#(
  parameter int            ADDR_W    = 8,
  parameter logic [7:0]    LOCK_ADDR = 8'h00,
  parameter logic [7:0]    STAT_ADDR = 8'h10,
  parameter logic [7:0]    EN_ADDR   = 8'h18,
  parameter logic [7:0]    DIS_ADDR  = 8'h1C,
  parameter logic [31:0]   PASSCODE  = 32'h0000DF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DataW-1:0]  busWrData,
  output regStrobe_t        strobe,
  output logic              locked
);

  logic hitLock, hitStat, hitEn, hitDis;

  always_comb begin
    hitLock = (busAddr == ADDR_W'(LOCK_ADDR));
    hitStat = (busAddr == ADDR_W'(STAT_ADDR));
    hitEn   = (busAddr == ADDR_W'(EN_ADDR));
    hitDis  = (busAddr == ADDR_W'(DIS_ADDR));
    strobe.lockWr  = busWrEn && hitLock;
    strobe.statW1c = busWrEn && !locked && hitStat;
    strobe.enWr    = busWrEn && !locked && hitEn;
    strobe.disWr   = busWrEn && !locked && hitDis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             locked <= 1'b1;
    else if (strobe.lockWr) locked <= (busWrData != PASSCODE);
  end

  // R1
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && hitLock && busWrData == PASSCODE) |=> !locked);

  // R3
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && hitLock && busWrData != PASSCODE) |=> locked);

  // R1
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWrEn && hitLock) |=> $stable(locked));

endmodule

// File: rtl/fuse_reg_dp.sv
module fuse_reg_dp
  import fuse_reg_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          NUM_SRC   = 15,
  parameter logic [7:0]  LOCK_ADDR = 8'h00,
  parameter logic [7:0]  STAT_ADDR = 8'h10,
  parameter logic [7:0]  MASK_ADDR = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobe_t        strobe,
  input  logic              locked,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DataW-1:0]  busWrData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic              busErrEvt,
  output logic [DataW-1:0]  busRdData,
  output logic              irqOut
);

  localparam int PadW = DataW - 1 - NUM_SRC;
  localparam logic [DataW-1:0] ImplMask = {1'b1, {PadW{1'b0}}, {NUM_SRC{1'b1}}};

  logic [DataW-1:0] stat;
  logic [DataW-1:0] mask;
  logic [DataW-1:0] evtVec;
  logic [DataW-1:0] clrVec;

  assign evtVec = {busErrEvt, {PadW{1'b0}}, evtPulse};
  assign clrVec = strobe.statW1c ? busWrData : '0;

  // One sticky cell per implemented status bit; reserved bits tie to zero
  for (genvar b = 0; b < DataW; b++) begin : gStat
    if (ImplMask[b]) begin : gLive
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat[b] <= 1'b0;
        else        stat[b] <= (stat[b] & ~clrVec[b]) | evtVec[b];
      end
    end else begin : gTie
      assign stat[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mask <= ImplMask;
    else if (strobe.enWr)  mask <= mask & ~(busWrData & ImplMask);
    else if (strobe.disWr) mask <= mask | (busWrData & ImplMask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqOut <= 1'b0;
    else        irqOut <= |(stat & ~mask);
  end

  always_comb begin
    if (busAddr == ADDR_W'(LOCK_ADDR))      busRdData = {{(DataW-1){1'b0}}, locked};
    else if (busAddr == ADDR_W'(STAT_ADDR)) busRdData = stat;
    else if (busAddr == ADDR_W'(MASK_ADDR)) busRdData = mask;
    else                                    busRdData = '0;
  end

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~ImplMask) == '0) && ((mask & ~ImplMask) == '0));

  // R5
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.statW1c |=> (($past(stat) & ~stat) == '0));

  // R5
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evtVec) |=> ((stat & $past(evtVec)) == $past(evtVec)));

  // R6
  mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.enWr || strobe.disWr) |=> $stable(mask));

  // R8
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~mask)) |=> irqOut);

  // R8
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & ~mask)) |=> !irqOut);

endmodule

// File: rtl/fuse_reg_front.sv
module fuse_reg_front
  import fuse_reg_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          NUM_SRC   = 15,
  parameter logic [31:0] PASSCODE  = 32'h0000DF0D,
  parameter logic [7:0]  LOCK_ADDR = 8'h00,
  parameter logic [7:0]  STAT_ADDR = 8'h10,
  parameter logic [7:0]  MASK_ADDR = 8'h14,
  parameter logic [7:0]  EN_ADDR   = 8'h18,
  parameter logic [7:0]  DIS_ADDR  = 8'h1C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               busErrEvt,
  output logic               irqOut
);

  regStrobe_t strobe;
  logic       locked;

  fuse_reg_ctrl #(
    .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .STAT_ADDR(STAT_ADDR),
    .EN_ADDR(EN_ADDR), .DIS_ADDR(DIS_ADDR), .PASSCODE(PASSCODE)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .strobe(strobe), .locked(locked)
  );

  fuse_reg_dp #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .LOCK_ADDR(LOCK_ADDR),
    .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .locked(locked),
    .busAddr(busAddr), .busWrData(busWrData), .evtPulse(evtPulse),
    .busErrEvt(busErrEvt), .busRdData(busRdData), .irqOut(irqOut)
  );

endmodule

// File: tb/sim_fuse_reg_front.sv
`timescale 1ns/1ps
module sim_fuse_reg_front;

  localparam logic [7:0] ALock = 8'h00, AStat = 8'h10, AMask = 8'h14,
                         AEn = 8'h18, ADis = 8'h1C, AFree = 8'h40;
  localparam logic [31:0] Impl = 32'h80007FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [14:0] evtPulse = '0;
  logic        busErrEvt = 1'b0;
  logic        irqOut;
  int          nRun = 0;
  int          nFail = 0;

  always #2 clk = ~clk;

  fuse_reg_front u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .evtPulse(evtPulse),
    .busErrEvt(busErrEvt), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic fire(input logic [15:0] v);
    @(negedge clk);
    evtPulse = v[14:0]; busErrEvt = v[15];
    @(negedge clk);
    evtPulse = '0; busErrEvt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd(ALock, d); check("R1 lock reset", d, 32'd1);
    rd(AMask, d); check("R6 mask reset", d, Impl);
    rd(AStat, d); check("R4 status reset", d, 32'd0);
    check("R8 irq reset", {31'd0, irqOut}, 32'd0);

    // Locked: writes dropped, events still land
    wr(AEn, 32'hFFFFFFFF);
    rd(AMask, d); check("R2 enable dropped while locked", d, Impl);
    fire(16'h0001);
    wr(AStat, 32'h00000001);
    rd(AStat, d); check("R2 w1c dropped while locked", d, 32'h1);

    // Passcode must match the whole word
    wr(ALock, 32'h0000DF0C); rd(ALock, d); check("R1 near passcode", d, 32'd1);
    wr(ALock, 32'h0001DF0D); rd(ALock, d); check("R1 upper bits set", d, 32'd1);
    wr(ALock, 32'h0000DF0D); rd(ALock, d); check("R1 passcode unlocks", d, 32'd0);

    wr(AStat, 32'h00000001);
    rd(AStat, d); check("R4 w1c after unlock", d, 32'd0);

    // Direct mask write ignored; unmapped address inert
    wr(AMask, 32'h0);
    rd(AMask, d); check("R6 direct mask write ignored", d, Impl);
    wr(AFree, 32'hFFFFFFFF);
    rd(AFree, d); check("R9 unmapped reads zero", d, 32'd0);
    rd(AMask, d); check("R9 unmapped write no effect", d, Impl);
    rd(AEn, d);  check("R7 enable reads zero", d, 32'd0);
    rd(ADis, d); check("R7 disable reads zero", d, 32'd0);

    // Reserved bits
    wr(ADis, 32'hFFFFFFFF);
    rd(AMask, d); check("R7 disable keeps reserved zero", d, Impl);
    fire(16'hFFFF);
    rd(AStat, d); check("R4 all events, reserved zero", d, Impl);
    @(negedge clk);
    check("R8 all masked irq low", {31'd0, irqOut}, 32'd0);
    wr(AStat, 32'hFFFFFFFF);
    rd(AStat, d); check("R4 clear all", d, 32'd0);

    // Sweep every source
    wr(AEn, 32'hFFFFFFFF);
    rd(AMask, d); check("R7 enable clears mask", d, 32'd0);
    for (int s = 0; s < 16; s++) begin
      logic [31:0] e;
      e = (s < 15) ? (32'd1 << s) : 32'h80000000;
      fire(16'd1 << s);
      rd(AStat, d); check($sformatf("R5 source %0d sets bit", s), d, e);
      check($sformatf("R8 source %0d irq not yet", s), {31'd0, irqOut}, 32'd0);
      @(negedge clk);
      check($sformatf("R8 source %0d irq raised", s), {31'd0, irqOut}, 32'd1);
      wr(ADis, e);
      rd(AMask, d); check($sformatf("R7 source %0d disable", s), d, e);
      @(negedge clk);
      check($sformatf("R8 source %0d masked irq low", s), {31'd0, irqOut}, 32'd0);
      wr(AEn, e);
      @(negedge clk);
      check($sformatf("R8 source %0d unmasked irq high", s), {31'd0, irqOut}, 32'd1);
      wr(AStat, e);
      rd(AStat, d); check($sformatf("R4 source %0d w1c", s), d, 32'd0);
      @(negedge clk);
      check($sformatf("R8 source %0d cleared irq low", s), {31'd0, irqOut}, 32'd0);
    end

    // Event and clear on the same bit in the same cycle
    @(negedge clk);
    busAddr = AStat; busWrData = 32'h8; busWrEn = 1'b1; evtPulse = 15'h0008;
    @(negedge clk);
    busWrEn = 1'b0; evtPulse = '0;
    rd(AStat, d); check("R5 event beats w1c", d, 32'h8);
    wr(AStat, 32'h8);

    // Relock while unlocked
    wr(ALock, 32'h00001234);
    rd(ALock, d); check("R3 relock", d, 32'd1);
    wr(ADis, 32'h1);
    rd(AMask, d); check("R2 disable dropped after relock", d, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule